// File: doc/BRIEF.md
# Dual-Role Serial Peripheral Controller with Master-Conflict Detection

This block is an 8-bit serial peripheral interface engine that works either as bus master or as slave on a shared bus. The bus has three data and clock wires plus one select wire. The role is chosen at run time.

As master, the block generates the serial clock from the system clock. It shifts one byte out on MOSI and, on the same clock edges, shifts one byte in on MISO. Its register and the peer's register act as a single 16-bit ring, so after one complete transfer the two bytes have swapped places. As slave, the block follows an external serial clock, but only while its select input is held low.

Two configuration bits decide what the select pin does. It can be a driven select output, a plain ignored input, or a conflict detector. As a conflict detector, a low level on the pin demotes the master to slave, cancels its transfer, releases its outputs and raises a sticky fault flag.

Top module: `spi_dual_role`

## Requirements
- R1: As master, a write while idle starts a transfer of 8 bits, most significant bit first. Afterwards the peer holds the written byte and `rx_data` holds the byte the peer held before the transfer.
- R2: As master, the serial clock idles low and is high for 2^`div_sel` system clocks in each bit. `div_sel` values 0 to 3 give a half period of 1, 2, 4 or 8 clocks.
- R3: `done_flag` sets when the eighth bit has been shifted in, at the same edge that loads `rx_data`. It stays set until `done_clr` is pulsed.
- R4: As slave, the block samples MOSI on rising edges and changes MISO on falling edges of the external clock, only while `ss_i` is low. `miso_oe` is high only while the synchronized `ss_i` is low. After 8 edges, `rx_data` holds the byte received.
- R5: As slave, raising `ss_i` in the middle of a byte resets the bit counter. The next selection then needs a full 8 bits before `done_flag` sets.
- R6: With `cfg_fault_off`=0, a master whose `ss_i` goes low clears `is_master`, stops the transfer without setting `done_flag`, drops `sclk_oe` and `mosi_oe`, and sets the sticky `fault_flag` until `fault_clr`.
- R7: With `cfg_fault_off`=1 and `cfg_ss_out`=1, a master drives `ss_oe`=1, with `ss_o` low during a transfer and high when idle.
- R8: With `cfg_fault_off`=1 and `cfg_ss_out`=0, the select pin is ignored. A master with `ss_i` held low completes its transfer and raises no fault.
- R9: A write while `busy` is high sets the sticky `wcol_flag` (cleared by `wcol_clr`) and leaves the byte being shifted unchanged.
- R10: After reset the block is a slave, with `sclk_oe`, `mosi_oe` and `ss_oe` low, all flags clear and `busy` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| role_wr | input | 1 | Pulse: load the role bit from role_master |
| role_master | input | 1 | Role value: 1 master, 0 slave |
| cfg_ss_out | input | 1 | Enables the select output in master role |
| cfg_fault_off | input | 1 | 1 turns off master-conflict detection |
| div_sel | input | 2 | Half-period select, 2^div_sel clocks |
| tx_wr | input | 1 | Pulse: write tx_data to the shift register |
| tx_data | input | 8 | Byte to transmit |
| done_clr | input | 1 | Clears done_flag |
| fault_clr | input | 1 | Clears fault_flag |
| wcol_clr | input | 1 | Clears wcol_flag |
| rx_data | output | 8 | Last byte received |
| done_flag | output | 1 | Sticky transfer-complete flag |
| fault_flag | output | 1 | Sticky master-conflict flag |
| wcol_flag | output | 1 | Sticky write-collision flag |
| busy | output | 1 | Transfer in progress |
| is_master | output | 1 | Current role bit |
| sclk_i | input | 1 | Serial clock from the bus |
| sclk_o | output | 1 | Serial clock driven in master role |
| sclk_oe | output | 1 | Output enable for sclk_o |
| mosi_i | input | 1 | MOSI from the bus |
| mosi_o | output | 1 | MOSI driven in master role |
| mosi_oe | output | 1 | Output enable for mosi_o |
| miso_i | input | 1 | MISO from the bus |
| miso_o | output | 1 | MISO driven in slave role |
| miso_oe | output | 1 | Output enable for miso_o |
| ss_i | input | 1 | Select pin input |
| ss_o | output | 1 | Select pin output value |
| ss_oe | output | 1 | Output enable for ss_o |

## Verification
The bench builds the block with its defaults: an 8-bit word, a 2-bit divider select and a two-stage input synchronizer. With the 2-bit select, all four half periods from 1 to 8 clocks can be tried. The one-clock half period is the tightest case, where the shift on the falling edge and the sample on the next rising edge are only one clock apart. In slave tests the bench holds each external clock phase for 8 clocks, which is longer than the synchronizer delay, so MISO can be checked ahead of every rising edge.

// File: rtl/spi_dr_pkg.sv
package spi_dr_pkg;

  // Number of system clocks in one serial clock phase for a divider select.
  function automatic int unsigned half_clocks(input int unsigned sel);
    return 32'd1 << sel;
  endfunction

  // Master-conflict detection is live unless switched off.
  function automatic logic fault_armed(input logic fault_off);
    return !fault_off;
  endfunction

  // Select pin is a driven output only with detection off and output enabled.
  function automatic logic ss_drives(input logic fault_off, input logic ss_out);
    return fault_off && ss_out;
  endfunction

endpackage

// File: rtl/spi_dr_sync.sv
module spi_dr_sync #(
  parameter int W       = 3,
  parameter int STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= RST_VAL;
        else        stg[0] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= RST_VAL;
        else        stg[s] <= stg[s-1];
      end
    end
  end

  assign dout = stg[STAGES-1];

endmodule

// File: rtl/spi_dr_clkgen.sv
module spi_dr_clkgen #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);

  localparam int CNT_W = (1 << SEL_W) - 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;

  assign limit = CNT_W'(spi_dr_pkg::half_clocks(32'(sel)) - 32'd1);
  assign tick  = run && (cnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (!run)      cnt <= '0;
    else if (tick)      cnt <= '0;
    else                cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/spi_dr_shifter.sv
module spi_dr_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  input  logic              cap_en,
  input  logic              cap_in,
  input  logic              shift_en,
  input  logic              cnt_clr,
  output logic              msb,
  output logic [DATA_W-1:0] next_word,
  output logic              word_done,
  output logic              cnt_nz
);

  localparam int CNT_W = $clog2(DATA_W);

  logic [DATA_W-1:0] sreg;
  logic              cap_q;
  logic [CNT_W-1:0]  cnt;

  assign msb       = sreg[DATA_W-1];
  assign next_word = {sreg[DATA_W-2:0], cap_q};
  assign word_done = shift_en && (cnt == CNT_W'(DATA_W-1));
  assign cnt_nz    = (cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg  <= '0;
      cap_q <= 1'b0;
    end else begin
      if (cap_en) cap_q <= cap_in;
      if (shift_en)  sreg <= next_word;
      else if (load) sreg <= load_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (cnt_clr)   cnt <= '0;
    else if (shift_en)  cnt <= word_done ? '0 : cnt + 1'b1;
  end

endmodule

// File: rtl/spi_dual_role.sv
module spi_dual_role #(
  parameter int DATA_W = 8,
  parameter int SEL_W  = 2,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              role_wr,
  input  logic              role_master,
  input  logic              cfg_ss_out,
  input  logic              cfg_fault_off,
  input  logic [SEL_W-1:0]  div_sel,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              done_clr,
  input  logic              fault_clr,
  input  logic              wcol_clr,
  output logic [DATA_W-1:0] rx_data,
  output logic              done_flag,
  output logic              fault_flag,
  output logic              wcol_flag,
  output logic              busy,
  output logic              is_master,
  input  logic              sclk_i,
  output logic              sclk_o,
  output logic              sclk_oe,
  input  logic              mosi_i,
  output logic              mosi_o,
  output logic              mosi_oe,
  input  logic              miso_i,
  output logic              miso_o,
  output logic              miso_oe,
  input  logic              ss_i,
  output logic              ss_o,
  output logic              ss_oe
);

  localparam int PIN_W = 3;
  localparam logic [PIN_W-1:0] PIN_RST = 3'b100;  // select idles high

  // Synchronized bus pins, ordered {select, mosi, sclk}
  logic [PIN_W-1:0] pins_s;
  logic sclk_s, mosi_s, ss_s, sclk_d;

  spi_dr_sync #(.W(PIN_W), .STAGES(SYNC_N), .RST_VAL(PIN_RST)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .din({ss_i, mosi_i, sclk_i}),
    .dout(pins_s)
  );
  assign {ss_s, mosi_s, sclk_s} = pins_s;

  // Role and master state
  logic master_q, busy_m, sclk_q;
  logic tick, m_rise, m_fall;
  logic s_active, s_rise, s_fall, busy_s;
  logic fault_hit, wr_ok, wr_clash, start;
  logic cap_in, cap_en, shift_en, cnt_clr;
  logic msb, word_done, cnt_nz;
  logic [DATA_W-1:0] next_word;

  spi_dr_clkgen #(.SEL_W(SEL_W)) u_clkgen (
    .clk(clk), .rst_n(rst_n), .run(busy_m), .sel(div_sel), .tick(tick)
  );

  assign m_rise   = tick && !sclk_q;
  assign m_fall   = tick &&  sclk_q;

  assign s_active = !master_q && !ss_s;
  assign s_rise   = s_active &&  sclk_s && !sclk_d;
  assign s_fall   = s_active && !sclk_s &&  sclk_d;

  assign fault_hit = master_q && spi_dr_pkg::fault_armed(cfg_fault_off) && !ss_s;
  assign busy_s    = s_active && cnt_nz;
  assign busy      = busy_m || busy_s;
  assign wr_ok     = tx_wr && !busy;
  assign wr_clash  = tx_wr &&  busy;
  assign start     = wr_ok && master_q && !fault_hit && !role_wr;

  assign cap_in   = master_q ? miso_i : mosi_s;
  assign cap_en   = m_rise || s_rise;
  assign shift_en = m_fall || s_fall;
  assign cnt_clr  = start || fault_hit || role_wr || (!master_q && ss_s);

  spi_dr_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .load(wr_ok), .load_val(tx_data),
    .cap_en(cap_en), .cap_in(cap_in),
    .shift_en(shift_en), .cnt_clr(cnt_clr),
    .msb(msb), .next_word(next_word),
    .word_done(word_done), .cnt_nz(cnt_nz)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_d <= 1'b0;
    else        sclk_d <= sclk_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         master_q <= 1'b0;
    else if (fault_hit) master_q <= 1'b0;
    else if (role_wr)   master_q <= role_master;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_m <= 1'b0;
      sclk_q <= 1'b0;
    end else if (fault_hit || role_wr) begin
      busy_m <= 1'b0;
      sclk_q <= 1'b0;
    end else if (start) begin
      busy_m <= 1'b1;
      sclk_q <= 1'b0;
    end else if (m_rise) begin
      sclk_q <= 1'b1;
    end else if (m_fall) begin
      sclk_q <= 1'b0;
      if (word_done) busy_m <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data    <= '0;
      done_flag  <= 1'b0;
      fault_flag <= 1'b0;
      wcol_flag  <= 1'b0;
    end else begin
      if (word_done) rx_data <= next_word;

      if (word_done)     done_flag <= 1'b1;
      else if (done_clr) done_flag <= 1'b0;

      if (fault_hit)      fault_flag <= 1'b1;
      else if (fault_clr) fault_flag <= 1'b0;

      if (wr_clash)      wcol_flag <= 1'b1;
      else if (wcol_clr) wcol_flag <= 1'b0;
    end
  end

  assign is_master = master_q;
  assign sclk_o    = sclk_q;
  assign sclk_oe   = master_q;
  assign mosi_o    = msb;
  assign mosi_oe   = master_q;
  assign miso_o    = msb;
  assign miso_oe   = !master_q && !ss_s;
  assign ss_oe     = master_q && spi_dr_pkg::ss_drives(cfg_fault_off, cfg_ss_out);
  assign ss_o      = !busy_m;

endmodule

// File: rtl/spi_dual_role_chk.sv
module spi_dual_role_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_ss_out,
  input logic cfg_fault_off,
  input logic tx_wr,
  input logic done_flag,
  input logic fault_flag,
  input logic wcol_flag,
  input logic busy,
  input logic is_master,
  input logic sclk_o,
  input logic sclk_oe,
  input logic mosi_oe,
  input logic miso_oe,
  input logic ss_o,
  input logic ss_oe
);

  // R3: completion is flagged at the edge that ends the transfer
  p_done_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_flag) |-> !busy);

  // R2: master clock rests low whenever no transfer runs
  p_sclk_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (is_master && !busy) |-> !sclk_o);

  // R6: clock and MOSI are released outside the master role
  p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !is_master |-> (!sclk_oe && !mosi_oe));

  // R6: a raised fault always comes with demotion
  p_fault_demote_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_flag) |-> !is_master);

  // R4: MISO is only driven in the slave role
  p_miso_slave_r4: assert property (@(posedge clk) disable iff (!rst_n)
    miso_oe |-> !is_master);

  // R7: driven select is low for the whole transfer
  p_ss_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (is_master && cfg_ss_out && cfg_fault_off && busy) |-> (ss_oe && !ss_o));

  // R8: with detection off no fault can appear
  p_no_fault_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (is_master && cfg_fault_off && !fault_flag) |=> !fault_flag);

  // R9: a write during a transfer is flagged
  p_wcol_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && tx_wr) |=> wcol_flag);

endmodule

bind spi_dual_role spi_dual_role_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_ss_out(cfg_ss_out), .cfg_fault_off(cfg_fault_off),
  .tx_wr(tx_wr), .done_flag(done_flag), .fault_flag(fault_flag), .wcol_flag(wcol_flag),
  .busy(busy), .is_master(is_master), .sclk_o(sclk_o), .sclk_oe(sclk_oe),
  .mosi_oe(mosi_oe), .miso_oe(miso_oe), .ss_o(ss_o), .ss_oe(ss_oe)
);

// File: tb/spi_dual_role_tb.sv
`timescale 1ns/1ps
module spi_dual_role_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic role_wr = 0, role_master = 0, cfg_ss_out = 0, cfg_fault_off = 1;
  logic [1:0] div_sel = 0;
  logic tx_wr = 0;
  logic [7:0] tx_data = 0;
  logic done_clr = 0, fault_clr = 0, wcol_clr = 0;
  logic [7:0] rx_data;
  logic done_flag, fault_flag, wcol_flag, busy, is_master;
  logic sclk_i = 0, mosi_i = 0, miso_i = 0, ss_i = 1;
  logic sclk_o, sclk_oe, mosi_o, mosi_oe, miso_o, miso_oe, ss_o, ss_oe;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;  // 50 MHz

  spi_dual_role u_dut (
    .clk(clk), .rst_n(rst_n), .role_wr(role_wr), .role_master(role_master),
    .cfg_ss_out(cfg_ss_out), .cfg_fault_off(cfg_fault_off), .div_sel(div_sel),
    .tx_wr(tx_wr), .tx_data(tx_data), .done_clr(done_clr), .fault_clr(fault_clr),
    .wcol_clr(wcol_clr), .rx_data(rx_data), .done_flag(done_flag),
    .fault_flag(fault_flag), .wcol_flag(wcol_flag), .busy(busy), .is_master(is_master),
    .sclk_i(sclk_i), .sclk_o(sclk_o), .sclk_oe(sclk_oe),
    .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
    .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe),
    .ss_i(ss_i), .ss_o(ss_o), .ss_oe(ss_oe)
  );

  function automatic int half_ns(input logic [1:0] sel);
    int n = 1;
    for (int k = 0; k < int'(sel); k++) n = n * 2;
    return 20 * n;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_wr(input logic [7:0] d);
    @(negedge clk); tx_data = d; tx_wr = 1;
    @(negedge clk); tx_wr = 0;
  endtask

  task automatic clear_flags();
    @(negedge clk); done_clr = 1; fault_clr = 1; wcol_clr = 1;
    @(negedge clk); done_clr = 0; fault_clr = 0; wcol_clr = 0;
  endtask

  task automatic set_role(input logic m);
    @(negedge clk); role_master = m; role_wr = 1;
    @(negedge clk); role_wr = 0;
  endtask

  // Master transfer against a bench slave model
  task automatic master_xfer(input logic [1:0] sel, input logic [7:0] tx,
                             input logic [7:0] pin, input bit chk_ss, input bit wcol);
    logic [7:0] peer;
    logic b;
    time tr, tf;
    div_sel = sel;
    peer = pin;
    miso_i = peer[7];
    pulse_wr(tx);
    for (int i = 0; i < 8; i++) begin
      @(posedge sclk_o); tr = $time; b = mosi_o;
      if (i == 2 && chk_ss) begin
        chk("R7 ss_oe during transfer", 32'(ss_oe), 1);
        chk("R7 ss_o low during transfer", 32'(ss_o), 0);
      end
      if (i == 3 && wcol) pulse_wr(~tx);
      @(negedge sclk_o); tf = $time;
      if (i == 0) chk("R2 high phase length", 32'(tf - tr), 32'(half_ns(sel)));
      peer = {peer[6:0], b};
      miso_i = peer[7];
    end
    @(negedge clk);
    chk("R1 rx_data", 32'(rx_data), 32'(pin));
    chk("R1 peer got tx", 32'(peer), 32'(tx));
    chk("R3 done_flag set", 32'(done_flag), 1);
    chk("R2 sclk idle low", 32'(sclk_o), 0);
    if (chk_ss) chk("R7 ss_o high idle", 32'(ss_o), 1);
    if (wcol)   chk("R9 wcol_flag", 32'(wcol_flag), 1);
    clear_flags();
    chk("R3 done_flag cleared", 32'(done_flag), 0);
  endtask

  // Slave transfer driven by the bench as external master
  task automatic slave_xfer(input logic [7:0] ld, input logic [7:0] m,
                            input int nb, input bit exp_done);
    pulse_wr(ld);
    idle(2);
    ss_i = 0;
    idle(6);
    chk("R4 miso_oe with select low", 32'(miso_oe), 1);
    for (int i = 0; i < nb; i++) begin
      mosi_i = m[7-i];
      idle(8);
      chk("R4 miso bit", 32'(miso_o), 32'(ld[7-i]));
      sclk_i = 1; idle(8);
      sclk_i = 0; idle(8);
    end
    idle(4);
    if (exp_done) begin
      chk("R4 slave rx_data", 32'(rx_data), 32'(m));
      chk("R3 slave done_flag", 32'(done_flag), 1);
    end else begin
      chk("R5 no done on partial byte", 32'(done_flag), 0);
    end
    ss_i = 1;
    idle(6);
    chk("R4 miso released", 32'(miso_oe), 0);
    clear_flags();
  endtask

  initial begin
    #4_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] a, m;
    void'($urandom(32'd4242));
    idle(3);
    rst_n = 1;
    idle(4);
    // R10 reset state
    chk("R10 is_master", 32'(is_master), 0);
    chk("R10 sclk_oe", 32'(sclk_oe), 0);
    chk("R10 mosi_oe", 32'(mosi_oe), 0);
    chk("R10 ss_oe", 32'(ss_oe), 0);
    chk("R10 flags", 32'({done_flag, fault_flag, wcol_flag}), 0);
    chk("R10 busy", 32'(busy), 0);

    // R4 slave transfers
    slave_xfer(8'hA5, 8'h3C, 8, 1);
    for (int t = 0; t < 3; t++) begin
      a = 8'($urandom); m = 8'($urandom);
      slave_xfer(a, m, 8, 1);
    end
    // R5 mid-byte deselect, then a full byte
    slave_xfer(8'hF0, 8'h55, 3, 0);
    slave_xfer(8'h96, 8'hC3, 8, 1);

    // R1/R2 master transfers, every divider then random
    set_role(1);
    cfg_fault_off = 1; cfg_ss_out = 0;
    chk("R1 master role", 32'(is_master), 1);
    master_xfer(2'd0, 8'h81, 8'h7E, 0, 0);
    master_xfer(2'd1, 8'h00, 8'hFF, 0, 0);
    master_xfer(2'd2, 8'hFF, 8'h00, 0, 0);
    master_xfer(2'd3, 8'h5A, 8'hA5, 0, 0);
    for (int t = 0; t < 8; t++) begin
      master_xfer(2'($urandom), 8'($urandom), 8'($urandom), 0, 0);
    end

    // R7 driven select
    cfg_ss_out = 1;
    idle(2);
    chk("R7 ss_o high before", 32'(ss_o), 1);
    master_xfer(2'd2, 8'h3D, 8'hB2, 1, 0);
    cfg_ss_out = 0;

    // R8 select ignored while held low
    ss_i = 0;
    idle(4);
    master_xfer(2'd1, 8'hC7, 8'h19, 0, 0);
    chk("R8 still master", 32'(is_master), 1);
    chk("R8 no fault", 32'(fault_flag), 0);
    ss_i = 1;
    idle(4);

    // R9 write collision keeps shifted byte intact
    master_xfer(2'd3, 8'h6B, 8'hD4, 0, 1);

    // R6 master conflict mid transfer
    cfg_fault_off = 0;
    idle(4);
    div_sel = 2'd3;
    pulse_wr(8'hE1);
    idle(20);
    ss_i = 0;
    idle(5);
    chk("R6 demoted", 32'(is_master), 0);
    chk("R6 sclk released", 32'(sclk_oe), 0);
    chk("R6 mosi released", 32'(mosi_oe), 0);
    chk("R6 fault_flag", 32'(fault_flag), 1);
    chk("R6 transfer stopped", 32'(busy), 0);
    chk("R6 no done", 32'(done_flag), 0);
    ss_i = 1;
    idle(4);
    clear_flags();
    chk("R6 fault cleared", 32'(fault_flag), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule